// File: doc/BRIEF.md
# Stack and Control-Flow Sequencer

This block carries out the stack-related part of an 8-bit processor's control flow. It owns the 8-bit stack pointer and the 16-bit program counter. It runs one multi-cycle command at a time: subroutine call, subroutine return, software break, interrupt return, push or pull of the accumulator or the status byte, and the two transfers between the stack pointer and the X index register. The caller supplies a 4-bit command code on `start`, together with the two operand bytes that were already fetched and the current accumulator, X and status values. The block then drives a synchronous byte-wide memory until it raises `done` for one cycle.

The stack always lives in one 256-byte page. A push stores the byte at page base + S and then decrements S. A pull first increments S and then reads page base + S. S wraps modulo 256 in both directions and no error is raised. The memory is registered: read data for an address driven in one cycle is sampled in the next cycle. Results that belong to registers outside the block (accumulator, X, status) come out with one-cycle write strobes that are high only in the `done` cycle. The program counter and stack pointer are already updated in that same cycle. Commands other than the control-flow ones leave the program counter unchanged, because instruction fetch is handled elsewhere.

Top module: `stkseq_top`

## Requirements
- R1: After reset, `pc` is RESET_PC (0x0400), `sp` is RESET_SP (0xFF), and `done`, `busy` and `mem_we` are low.
- R2: Every stack access uses address {STACK_PAGE, S} with STACK_PAGE = 0x01. A push writes at 0x0100+S and then S decreases by 1. A pull raises S by 1 and then reads 0x0100+S. `mem_we` is high only in push cycles.
- R3: S wraps modulo 256. A push at S=0x00 writes 0x0100 and leaves S=0xFF. A pull at S=0xFF reads 0x0100 and leaves S=0x00.
- R4: Command 0 (call) writes the high byte of PC+2 and then its low byte. It then loads PC = {opnd_hi, opnd_lo}. `done` comes 3 cycles after the start edge.
- R5: Command 1 (return) pulls the low byte and then the high byte, and loads PC = pulled value + 1 (modulo 2^16). `done` comes after 3 cycles.
- R6: Command 2 (break) pushes the high and low bytes of PC+2, then the status byte with bits 5 and 4 forced to 1. It then reads 0xFFFE (new PC low) and 0xFFFF (new PC high). It outputs the status with bit 2 (interrupt disable) set and `p_we` high. `done` comes after 6 cycles.
- R7: Command 3 (interrupt return) pulls the status byte, then the PC low byte, then the PC high byte, and loads the PC with no +1. `p_out` takes bits 7,6,3,2,1,0 from the pulled byte and bits 5,4 from `p_in`. `done` comes after 4 cycles.
- R8: Commands 4 and 5 push `acc_in` or (`p_in` with bits 5,4 set to 1) respectively. `done` comes after 2 cycles, with no result strobe.
- R9: Command 6 pulls a byte into `acc_out` (`acc_we`). It sets `p_out` = `p_in` with bit 7 = byte bit 7 and bit 1 = (byte == 0). Command 7 pulls the status byte using the R7 bit rule (`p_we` only). Both give `done` after 2 cycles.
- R10: Command 8 copies S into `x_out` (`x_we`) and sets `p_out` bit 7 and bit 1 from S (`p_we`). Command 9 loads S from `x_in` and raises no strobe. Both give `done` after 1 cycle.
- R11: `done` is a one-cycle pulse. `acc_we`, `x_we` and `p_we` are high only when `done` is high. `busy` is high from the start edge until `done`, and `start` is ignored while `busy` is high. Codes 10 to 15 access no memory, change neither S nor PC, and give `done` after 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command when idle |
| cmd | input | 4 | Command code |
| opnd_lo | input | 8 | First operand byte (call target low) |
| opnd_hi | input | 8 | Second operand byte (call target high) |
| acc_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X index register |
| p_in | input | 8 | Current status byte |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| x_out | output | 8 | New X value |
| x_we | output | 1 | X write strobe |
| p_out | output | 8 | New status value |
| p_we | output | 1 | Status write strobe |

## Verification
Each command takes a fixed number of cycles from the clock edge that samples `start` to the cycle where `done` is high: 1 for transfers and unknown codes, 2 for single pushes and pulls, 3 for call and return, 4 for interrupt return and 6 for break. PC, S and the result strobes are all valid in that `done` cycle. The bench drives `start` at a falling edge and counts falling edges until `done`. It compares the count with the cycle figure above and then samples every result at that same falling edge. Memory writes are logged on the rising edge where `mem_we` is high, so their order and addresses are checked against the push order.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  localparam logic [3:0] CMD_CALL   = 4'd0;
  localparam logic [3:0] CMD_RET    = 4'd1;
  localparam logic [3:0] CMD_BRK    = 4'd2;
  localparam logic [3:0] CMD_IRET   = 4'd3;
  localparam logic [3:0] CMD_PUSH_A = 4'd4;
  localparam logic [3:0] CMD_PUSH_P = 4'd5;
  localparam logic [3:0] CMD_PULL_A = 4'd6;
  localparam logic [3:0] CMD_PULL_P = 4'd7;
  localparam logic [3:0] CMD_S2X    = 4'd8;
  localparam logic [3:0] CMD_X2S    = 4'd9;

  localparam int FLAG_N = 7;
  localparam int FLAG_V = 6;
  localparam int FLAG_U = 5;
  localparam int FLAG_B = 4;
  localparam int FLAG_D = 3;
  localparam int FLAG_I = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PSH_PCH, ST_PSH_PCL, ST_PSH_BYTE, ST_PUL_BYTE,
    ST_PUL_PCL, ST_PUL_PCH, ST_VEC_LO, ST_VEC_HI, ST_FIN
  } seq_state_e;

  function automatic addr_t stack_addr(input byte_t page, input byte_t s);
    return {page, s};
  endfunction

  function automatic addr_t call_return_addr(input addr_t pc_now);
    return pc_now + addr_t'(2);
  endfunction

  function automatic addr_t sub_return_target(input byte_t hi, input byte_t lo);
    return {hi, lo} + addr_t'(1);
  endfunction

  function automatic byte_t status_pushed(input byte_t p);
    byte_t r = p;
    r[FLAG_B] = 1'b1;
    r[FLAG_U] = 1'b1;
    return r;
  endfunction

  function automatic byte_t status_pulled(input byte_t pulled, input byte_t cur);
    byte_t r = pulled;
    r[FLAG_B] = cur[FLAG_B];
    r[FLAG_U] = cur[FLAG_U];
    return r;
  endfunction

  function automatic byte_t set_nz(input byte_t p, input byte_t v);
    byte_t r = p;
    r[FLAG_N] = v[DW-1];
    r[FLAG_Z] = (v == '0);
    return r;
  endfunction
endpackage

// File: rtl/stkseq_sp.sv
module stkseq_sp
  import stkseq_pkg::*;
#(
  parameter byte_t RESET_SP   = 8'hFF,
  parameter byte_t STACK_PAGE = 8'h01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_step,
  input  logic  pull_step,
  input  logic  load_en,
  input  byte_t load_val,
  output byte_t sp,
  output addr_t push_addr,
  output addr_t pull_addr
);
  byte_t sp_q;
  byte_t sp_up;

  assign sp_up = sp_q + byte_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)         sp_q <= RESET_SP;
    else if (load_en)   sp_q <= load_val;
    else if (push_step) sp_q <= sp_q - byte_t'(1);
    else if (pull_step) sp_q <= sp_up;
  end

  assign sp        = sp_q;
  assign push_addr = stack_addr(STACK_PAGE, sp_q);
  assign pull_addr = stack_addr(STACK_PAGE, sp_up);

  // R2
  sp_op_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_step, pull_step, load_en}));

  // R3
  sp_pull_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_step && sp_q == 8'hFF) |=> (sp == 8'h00));
endmodule

// File: rtl/stkseq_pc.sv
module stkseq_pc
  import stkseq_pkg::*;
#(
  parameter addr_t RESET_PC = 16'h0400
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  addr_t load_val,
  output addr_t pc,
  output addr_t ret_addr
);
  addr_t pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= RESET_PC;
    else if (load_en) pc_q <= load_val;
  end

  assign pc       = pc_q;
  assign ret_addr = call_return_addr(pc_q);

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (pc == $past(pc)));
endmodule

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
#(
  parameter byte_t STACK_PAGE = 8'h01,
  parameter addr_t VEC_ADDR   = 16'hFFFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] cmd,
  input  byte_t      opnd_lo,
  input  byte_t      opnd_hi,
  input  byte_t      acc_in,
  input  byte_t      x_in,
  input  byte_t      p_in,
  input  byte_t      mem_rdata,
  input  byte_t      sp,
  input  addr_t      push_addr,
  input  addr_t      pull_addr,
  input  addr_t      ret_pc,
  output addr_t      mem_addr,
  output byte_t      mem_wdata,
  output logic       mem_we,
  output logic       busy,
  output logic       done,
  output logic       sp_push,
  output logic       sp_pull,
  output logic       sp_load,
  output byte_t      sp_load_val,
  output logic       pc_load,
  output addr_t      pc_load_val,
  output byte_t      acc_out,
  output logic       acc_we,
  output byte_t      x_out,
  output logic       x_we,
  output byte_t      p_out,
  output logic       p_we
);
  localparam addr_t VEC_ADDR_HI = VEC_ADDR + addr_t'(1);

  seq_state_e state_q, state_d;
  logic [3:0] cmd_q;
  byte_t      opl_q, oph_q, acc_q, x_q, p_q;
  byte_t      lo_q, pstk_q;
  logic       done_q, acc_we_q, x_we_q, p_we_q;
  byte_t      acc_out_q, x_out_q, p_out_q;

  // event wires for checks
  logic accept;
  logic stk_access;
  logic in_push;
  logic in_pull;
  logic finishing;

  assign accept     = (state_q == ST_IDLE) && start;
  assign in_push    = (state_q == ST_PSH_PCH) || (state_q == ST_PSH_PCL) ||
                      (state_q == ST_PSH_BYTE);
  assign in_pull    = (state_q == ST_PUL_BYTE) || (state_q == ST_PUL_PCL) ||
                      (state_q == ST_PUL_PCH);
  assign stk_access = in_push || in_pull;
  assign finishing  = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          case (cmd)
            CMD_CALL, CMD_BRK:                 state_d = ST_PSH_PCH;
            CMD_RET:                           state_d = ST_PUL_PCL;
            CMD_IRET, CMD_PULL_A, CMD_PULL_P:  state_d = ST_PUL_BYTE;
            CMD_PUSH_A, CMD_PUSH_P:            state_d = ST_PSH_BYTE;
            default:                           state_d = ST_FIN;
          endcase
        end
      end
      ST_PSH_PCH:  state_d = ST_PSH_PCL;
      ST_PSH_PCL:  state_d = (cmd_q == CMD_BRK) ? ST_PSH_BYTE : ST_FIN;
      ST_PSH_BYTE: state_d = (cmd_q == CMD_BRK) ? ST_VEC_LO : ST_FIN;
      ST_PUL_BYTE: state_d = (cmd_q == CMD_IRET) ? ST_PUL_PCL : ST_FIN;
      ST_PUL_PCL:  state_d = ST_PUL_PCH;
      ST_PUL_PCH:  state_d = ST_FIN;
      ST_VEC_LO:   state_d = ST_VEC_HI;
      ST_VEC_HI:   state_d = ST_FIN;
      ST_FIN:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // memory and stack pointer drive
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    sp_push   = 1'b0;
    sp_pull   = 1'b0;
    case (state_q)
      ST_PSH_PCH: begin
        mem_addr  = push_addr;
        mem_wdata = ret_pc[AW-1:DW];
        mem_we    = 1'b1;
        sp_push   = 1'b1;
      end
      ST_PSH_PCL: begin
        mem_addr  = push_addr;
        mem_wdata = ret_pc[DW-1:0];
        mem_we    = 1'b1;
        sp_push   = 1'b1;
      end
      ST_PSH_BYTE: begin
        mem_addr  = push_addr;
        mem_wdata = (cmd_q == CMD_PUSH_A) ? acc_q : status_pushed(p_q);
        mem_we    = 1'b1;
        sp_push   = 1'b1;
      end
      ST_PUL_BYTE, ST_PUL_PCL, ST_PUL_PCH: begin
        mem_addr = pull_addr;
        sp_pull  = 1'b1;
      end
      ST_VEC_LO: mem_addr = VEC_ADDR;
      ST_VEC_HI: mem_addr = VEC_ADDR_HI;
      default: ;
    endcase
  end

  // completion-time updates of S and PC
  always_comb begin
    sp_load     = finishing && (cmd_q == CMD_X2S);
    sp_load_val = x_q;
    pc_load     = finishing && ((cmd_q == CMD_CALL) || (cmd_q == CMD_RET) ||
                                (cmd_q == CMD_BRK)  || (cmd_q == CMD_IRET));
    case (cmd_q)
      CMD_CALL: pc_load_val = {oph_q, opl_q};
      CMD_RET:  pc_load_val = sub_return_target(mem_rdata, lo_q);
      default:  pc_load_val = {mem_rdata, lo_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= '0;
      opl_q     <= '0;
      oph_q     <= '0;
      acc_q     <= '0;
      x_q       <= '0;
      p_q       <= '0;
      lo_q      <= '0;
      pstk_q    <= '0;
      done_q    <= 1'b0;
      acc_we_q  <= 1'b0;
      x_we_q    <= 1'b0;
      p_we_q    <= 1'b0;
      acc_out_q <= '0;
      x_out_q   <= '0;
      p_out_q   <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= 1'b0;
      acc_we_q <= 1'b0;
      x_we_q   <= 1'b0;
      p_we_q   <= 1'b0;
      if (accept) begin
        cmd_q <= cmd;
        opl_q <= opnd_lo;
        oph_q <= opnd_hi;
        acc_q <= acc_in;
        x_q   <= x_in;
        p_q   <= p_in;
      end
      if (state_q == ST_PUL_PCL && cmd_q == CMD_IRET) pstk_q <= mem_rdata;
      if (state_q == ST_PUL_PCH || state_q == ST_VEC_HI) lo_q <= mem_rdata;
      if (finishing) begin
        done_q <= 1'b1;
        case (cmd_q)
          CMD_BRK: begin
            p_out_q         <= p_q;
            p_out_q[FLAG_I] <= 1'b1;
            p_we_q          <= 1'b1;
          end
          CMD_IRET: begin
            p_out_q <= status_pulled(pstk_q, p_q);
            p_we_q  <= 1'b1;
          end
          CMD_PULL_P: begin
            p_out_q <= status_pulled(mem_rdata, p_q);
            p_we_q  <= 1'b1;
          end
          CMD_PULL_A: begin
            acc_out_q <= mem_rdata;
            acc_we_q  <= 1'b1;
            p_out_q   <= set_nz(p_q, mem_rdata);
            p_we_q    <= 1'b1;
          end
          CMD_S2X: begin
            x_out_q <= sp;
            x_we_q  <= 1'b1;
            p_out_q <= set_nz(p_q, sp);
            p_we_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign acc_out = acc_out_q;
  assign acc_we  = acc_we_q;
  assign x_out   = x_out_q;
  assign x_we    = x_we_q;
  assign p_out   = p_out_q;
  assign p_we    = p_we_q;

  // R2
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_access |-> (mem_addr[AW-1:DW] == STACK_PAGE));

  // R2
  write_only_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> in_push);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  strobe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we || x_we || p_we) |-> done);

  // R11
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cmd_q == $past(cmd_q)));

  // R6
  brk_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && p_we && cmd_q == CMD_BRK) |-> p_out[FLAG_I]);
endmodule

// File: rtl/stkseq_top.sv
module stkseq_top
  import stkseq_pkg::*;
#(
  parameter logic [15:0] RESET_PC   = 16'h0400,
  parameter logic [7:0]  RESET_SP   = 8'hFF,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  cmd,
  input  logic [7:0]  opnd_lo,
  input  logic [7:0]  opnd_hi,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  p_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  acc_out,
  output logic        acc_we,
  output logic [7:0]  x_out,
  output logic        x_we,
  output logic [7:0]  p_out,
  output logic        p_we
);
  logic  sp_push, sp_pull, sp_load, pc_load;
  byte_t sp_load_val;
  addr_t pc_load_val, push_addr, pull_addr, ret_pc;

  stkseq_sp #(.RESET_SP(RESET_SP), .STACK_PAGE(STACK_PAGE)) u_sp (
    .clk(clk), .rst_n(rst_n), .push_step(sp_push), .pull_step(sp_pull),
    .load_en(sp_load), .load_val(sp_load_val), .sp(sp),
    .push_addr(push_addr), .pull_addr(pull_addr)
  );

  stkseq_pc #(.RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .load_en(pc_load), .load_val(pc_load_val),
    .pc(pc), .ret_addr(ret_pc)
  );

  stkseq_ctrl #(.STACK_PAGE(STACK_PAGE), .VEC_ADDR(VEC_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .acc_in(acc_in), .x_in(x_in),
    .p_in(p_in), .mem_rdata(mem_rdata), .sp(sp), .push_addr(push_addr),
    .pull_addr(pull_addr), .ret_pc(ret_pc), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
    .sp_push(sp_push), .sp_pull(sp_pull), .sp_load(sp_load),
    .sp_load_val(sp_load_val), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .acc_out(acc_out), .acc_we(acc_we), .x_out(x_out), .x_we(x_we),
    .p_out(p_out), .p_we(p_we)
  );

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 8'd1));

  // R11
  idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
endmodule

// File: tb/tb_stkseq_top.sv
module tb_stkseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cmd = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, acc_in = '0, x_in = '0, p_in = '0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, busy, done;
  logic [15:0] pc;
  logic [7:0]  sp, acc_out, x_out, p_out;
  logic        acc_we, x_we, p_we;

  localparam logic [7:0] VLO = 8'hCD;
  localparam logic [7:0] VHI = 8'hAB;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [7:0]  stk [0:255];
  logic [15:0] wr_addr [0:15];
  logic [7:0]  wr_data [0:15];
  int          wr_n = 0;

  stkseq_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .acc_in(acc_in), .x_in(x_in), .p_in(p_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .busy(busy), .done(done), .pc(pc), .sp(sp),
    .acc_out(acc_out), .acc_we(acc_we), .x_out(x_out), .x_we(x_we),
    .p_out(p_out), .p_we(p_we)
  );

  always #10 clk = ~clk;

  // registered memory model: stack page plus the two vector bytes
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
      wr_addr[wr_n % 16] <= mem_addr;
      wr_data[wr_n % 16] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
    if (mem_addr[15:8] == 8'h01)  mem_rdata <= stk[mem_addr[7:0]];
    else if (mem_addr == 16'hFFFE) mem_rdata <= VLO;
    else if (mem_addr == 16'hFFFF) mem_rdata <= VHI;
    else                           mem_rdata <= 8'h00;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_wr(input string req, input int idx, input logic [15:0] a, input logic [7:0] d);
    check({req, " write addr"}, 32'(wr_addr[idx % 16]), 32'(a));
    check({req, " write data"}, 32'(wr_data[idx % 16]), 32'(d));
  endtask

  int          lat;
  logic        s_acc_we, s_x_we, s_p_we;

  task automatic run(input logic [3:0] c, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [7:0] a, input logic [7:0] x, input logic [7:0] p);
    @(negedge clk);
    cmd = c; opnd_lo = lo; opnd_hi = hi; acc_in = a; x_in = x; p_in = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 20);
    s_acc_we = acc_we; s_x_we = x_we; s_p_we = p_we;
  endtask

  task automatic t_reset;
    check("R1 pc", 32'(pc), 32'h0400);
    check("R1 sp", 32'(sp), 32'hFF);
    check("R1 done/busy/we", {29'd0, done, busy, mem_we}, 32'd0);
  endtask

  task automatic t_call;
    int base = wr_n;
    run(4'd0, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00);
    check("R4 latency", lat, 3);
    check("R4 write count", wr_n - base, 2);
    check_wr("R4 high first", base, 16'h01FF, 8'h04);
    check_wr("R4 low second", base + 1, 16'h01FE, 8'h02);
    check("R4 pc", 32'(pc), 32'h1234);
    check("R2 sp after push", 32'(sp), 32'hFD);
    check("R4 no strobes", {s_acc_we, s_x_we, s_p_we}, 0);
  endtask

  task automatic t_ret;
    run(4'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R5 latency", lat, 3);
    check("R5 pc plus one", 32'(pc), 32'h0403);
    check("R2 sp after pull", 32'(sp), 32'hFF);
  endtask

  task automatic t_wrap;
    int base;
    run(4'd9, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00);
    base = wr_n;
    run(4'd4, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00);
    run(4'd4, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00);
    check("R8 latency", lat, 2);
    check_wr("R3 push at 00", base + 1, 16'h0100, 8'hFF);
    check("R3 sp wrap down", 32'(sp), 32'hFF);
    run(4'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R3 pull wrap pc", 32'(pc), 32'h0000);
    check("R3 sp wrap up", 32'(sp), 32'h01);
  endtask

  task automatic t_push_pull;
    int base = wr_n;
    run(4'd4, 8'h00, 8'h00, 8'h5A, 8'h00, 8'h00);
    run(4'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC3);
    check("R8 push count", wr_n - base, 2);
    check_wr("R8 push A", base, 16'h0101, 8'h5A);
    check_wr("R8 push P B/U set", base + 1, 16'h0100, 8'hF3);
    check("R8 no strobe", {s_acc_we, s_x_we, s_p_we}, 0);
    run(4'd7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R9 pull P latency", lat, 2);
    check("R9 pull P value", 32'(p_out), 32'hC3);
    check("R9 pull P strobes", {s_acc_we, s_x_we, s_p_we}, 3'b001);
    run(4'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h82);
    check("R9 pull A value", 32'(acc_out), 32'h5A);
    check("R9 pull A flags", 32'(p_out), 32'h00);
    check("R9 pull A strobes", {s_acc_we, s_x_we, s_p_we}, 3'b101);
    check("R2 sp after pulls", 32'(sp), 32'h01);
    run(4'd4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run(4'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80);
    check("R9 pull zero flags", 32'(p_out), 32'h02);
  endtask

  task automatic t_transfer;
    run(4'd9, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h00);
    check("R10 load S latency", lat, 1);
    check("R10 load S", 32'(sp), 32'hF0);
    check("R10 load S no strobe", {s_acc_we, s_x_we, s_p_we}, 0);
    run(4'd8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R10 copy S", 32'(x_out), 32'hF0);
    check("R10 copy flags", 32'(p_out), 32'h80);
    check("R10 copy strobes", {s_acc_we, s_x_we, s_p_we}, 3'b011);
  endtask

  task automatic t_brk_rti;
    int base = wr_n;
    run(4'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
    check("R6 latency", lat, 6);
    check("R6 write count", wr_n - base, 3);
    check_wr("R6 pc high", base, 16'h01F0, 8'h00);
    check_wr("R6 pc low", base + 1, 16'h01EF, 8'h02);
    check_wr("R6 status", base + 2, 16'h01EE, 8'h31);
    check("R6 vector pc", 32'(pc), 32'hABCD);
    check("R6 I set", 32'(p_out), 32'h05);
    check("R6 strobes", {s_acc_we, s_x_we, s_p_we}, 3'b001);
    check("R6 sp", 32'(sp), 32'hED);
    run(4'd3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R7 latency", lat, 4);
    check("R7 pc no plus one", 32'(pc), 32'h0002);
    check("R7 status", 32'(p_out), 32'h01);
    check("R7 sp", 32'(sp), 32'hF0);
  endtask

  task automatic t_unknown;
    int base = wr_n;
    run(4'hC, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00);
    check("R11 unknown latency", lat, 1);
    check("R11 unknown no write", wr_n - base, 0);
    check("R11 unknown sp", 32'(sp), 32'hF0);
    check("R11 unknown pc", 32'(pc), 32'h0002);
    check("R11 unknown strobes", {s_acc_we, s_x_we, s_p_we}, 0);
  endtask

  task automatic t_busy_ignore;
    int base = wr_n;
    int k;
    @(negedge clk);
    cmd = 4'd0; opnd_lo = 8'h78; opnd_hi = 8'h56; start = 1'b1;
    @(negedge clk);
    cmd = 4'd4; acc_in = 8'h99;
    check("R11 busy high", 32'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
    check("R11 busy latency", k, 3);
    check("R11 ignored start writes", wr_n - base, 2);
    check_wr("R11 call high", base, 16'h01F0, 8'h00);
    check_wr("R11 call low", base + 1, 16'h01EF, 8'h04);
    check("R11 ignored start sp", 32'(sp), 32'hEE);
    check("R11 ignored start pc", 32'(pc), 32'h5678);
    @(negedge clk);
    check("R11 done pulse", 32'(done), 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call();
    t_ret();
    t_wrap();
    t_push_pull();
    t_transfer();
    t_brk_rti();
    t_unknown();
    t_busy_ignore();
    finish_run();
  end

  initial begin
    #(20 * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule